// File: doc/BRIEF.md
# Processor Reset Initialization Sequencer

This block walks a processor through a fixed start-up routine once reset is released. Every step is offered on a command interface as a strobe together with a 16-bit command code, a 16-bit data word, a command kind and the machine-cycle type that the step occupies. The step is held until the consumer accepts it with `step_ack`, and the block then moves on to the next step. Steps that are purely internal to the processor are offered too, tagged with their own kind and cycle type, so that the consumer sees one entry per machine cycle.

The route through the routine depends on three presence inputs. An optional output discrete register gets an external clear. An optional bus protection unit has its 128-word protection RAM cleared by a counted loop. An optional memory management unit has its 256 instruction-page and 256 operand-page registers loaded with identity values by a second counted loop. A flag step then records whether the page loop ran. The routine ends with start-up ROM enable, timer starts, and two instruction-pipeline loads from memory at the instruction counter. After that, `done` rises and stays high until the next reset.

Top module: `isq_init_seq`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `cmd_valid`=1, `done`=0 and `mmu_flag`=0. The offered step is the status-word clear: kind 0, code 0000H, data 0, type B1.
- R2: While `cmd_valid` is high and `step_ack` is low, `cmd_code`, `cmd_data`, `cmd_kind` and `cyc_type` do not change. A step advances only on a clock edge where `step_ack` is high.
- R3: The opening steps come in this order: status-word clear (kind 0), mask clear 2000H, pending/fault clear 2001H, instruction-counter clear (kind 0, code 0), interrupt disable 2003H, MMU status clear, DMA disable 4007H, and configuration read 8400H. Codes of kind 0 steps are 0000H, and data is 0 unless stated otherwise.
- R4: The MMU status clear (code 200EH) is issued whatever the presence inputs are.
- R5: After the configuration read, an external clear step (kind 2, code 0000H, type I/O) appears only when `odr_present` is 1.
- R6: When `bpu_present` is 1, 128 steps follow with code 5000H plus address. The address runs 0,1,…,127 in the low byte. When the loop ends, control goes to the MMU check. With `bpu_present` 0 no such step appears.
- R7: When `mmu_present` is 1, 256 pairs follow. Each pair is code 5100H plus i, then code 5200H plus i, both carrying data i, for i = 0 to 255 in order. With `mmu_present` 0 none appear.
- R8: A flag step (kind 0, code 0, type B1) always follows the presence checks. In the cycle after it is accepted, `mmu_flag` equals `mmu_present`. `mmu_flag` does not change at any other time.
- R9: After the flag step come 4004H, 400AH, 400BH and 400EH, in that order.
- R10: Two memory-load steps follow (kind 3, code 0). Their data is the instruction counter: 0000H on the first load and 0001H on the second.
- R11: Kind encoding: 0 internal operation, 1 internal I/O command, 2 external I/O, 3 memory read. Cycle-type encoding: P=0, I/O=1, M=2, B1=3, B2=4. The types are assigned as follows:
  - B1 for kind 0;
  - P for single internal I/O commands;
  - B2 for the configuration read;
  - I/O for the external clear and all loop commands;
  - M for the loads.
- R12: Once the second load is accepted, `done`=1 and `cmd_valid`=0 from the next cycle on. Both hold whatever `step_ack` does.
- R13: Asserting `rst_n` low at any point, including inside a loop, restarts the routine from the status-word clear. The flag is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; restarts the routine |
| odr_present | input | 1 | Output discrete register fitted |
| bpu_present | input | 1 | Bus protection unit fitted |
| mmu_present | input | 1 | Memory management unit fitted |
| step_ack | input | 1 | Consumer accepts the offered step |
| cmd_valid | output | 1 | A step is being offered |
| cmd_code | output | 16 | Command code of the step |
| cmd_data | output | 16 | Data word of the step |
| cmd_kind | output | 2 | Step kind (R11 encoding) |
| cyc_type | output | 3 | Machine-cycle type (R11 encoding) |
| mmu_flag | output | 1 | Temporary flag: page loop was run |
| done | output | 1 | Routine finished |

## Verification
The riskiest coincidence is an accept of a loop's final step. On that one edge the loop counter must return to zero and the presence-dependent route must select the next phase. A fault in either shows up as a wrong code on the following step. The bench runs every combination of the three presence inputs with randomly stalled accepts, so the final-index accept falls on all three exits: LMP to pages, LMP to flag, and pages to flag. A behavioural model built from the requirements is compared against the outputs in every cycle. A reset is also dropped in the middle of the clear loop, to show that the counters and the flag restart together with the phase.

// File: rtl/isq_pkg.sv
package isq_pkg;

    typedef enum logic [4:0] {
        PH_STS, PH_MASK, PH_PIFT, PH_ICCLR, PH_INTDIS, PH_MMUSW, PH_DMADIS,
        PH_CFGRD, PH_ODR, PH_LMP, PH_WIPR, PH_WOPR, PH_FLAG,
        PH_ESUR, PH_OTA, PH_GO, PH_OTB, PH_LD1, PH_LD2, PH_DONE
    } phase_e;

    typedef enum logic [2:0] {
        CT_P  = 3'd0,
        CT_IO = 3'd1,
        CT_M  = 3'd2,
        CT_B1 = 3'd3,
        CT_B2 = 3'd4
    } ctype_e;

    typedef enum logic [1:0] {
        K_OP     = 2'd0,
        K_INT_IO = 2'd1,
        K_EXT_IO = 2'd2,
        K_MEM_RD = 2'd3
    } kind_e;

    localparam logic [15:0] C_MASK   = 16'h2000;
    localparam logic [15:0] C_PIFT   = 16'h2001;
    localparam logic [15:0] C_INTDIS = 16'h2003;
    localparam logic [15:0] C_MMUSW  = 16'h200E;
    localparam logic [15:0] C_DMADIS = 16'h4007;
    localparam logic [15:0] C_CFGRD  = 16'h8400;
    localparam logic [15:0] C_ESUR   = 16'h4004;
    localparam logic [15:0] C_OTA    = 16'h400A;
    localparam logic [15:0] C_GO     = 16'h400B;
    localparam logic [15:0] C_OTB    = 16'h400E;
    localparam logic [7:0]  C_LMP_HI  = 8'h50;
    localparam logic [7:0]  C_WIPR_HI = 8'h51;
    localparam logic [7:0]  C_WOPR_HI = 8'h52;

endpackage

// File: rtl/isq_route.sv
module isq_route
    import isq_pkg::*;
(
    input  logic   odr_present,
    input  logic   bpu_present,
    input  logic   mmu_present,
    output phase_e after_cfg,
    output phase_e after_odr,
    output phase_e after_bpu
);
    // Each checkpoint falls through to the next when its unit is absent.
    always_comb begin
        after_bpu = mmu_present ? PH_WIPR : PH_FLAG;
        after_odr = bpu_present ? PH_LMP  : after_bpu;
        after_cfg = odr_present ? PH_ODR  : after_odr;
    end
endmodule

// File: rtl/isq_step_rom.sv
module isq_step_rom
    import isq_pkg::*;
(
    input  phase_e      phase,
    input  logic [7:0]  clr_idx,
    input  logic [7:0]  pg_idx,
    input  logic [15:0] ic,
    output logic [15:0] code,
    output logic [15:0] data,
    output kind_e       kind,
    output ctype_e      ctype
);
    always_comb begin
        code  = 16'h0000;
        data  = 16'h0000;
        kind  = K_INT_IO;
        ctype = CT_P;
        case (phase)
            PH_STS, PH_ICCLR, PH_FLAG: begin
                kind  = K_OP;
                ctype = CT_B1;
            end
            PH_MASK:   code = C_MASK;
            PH_PIFT:   code = C_PIFT;
            PH_INTDIS: code = C_INTDIS;
            PH_MMUSW:  code = C_MMUSW;
            PH_DMADIS: code = C_DMADIS;
            PH_CFGRD: begin
                code  = C_CFGRD;
                ctype = CT_B2;
            end
            PH_ODR: begin
                kind  = K_EXT_IO;
                ctype = CT_IO;
            end
            PH_LMP: begin
                code  = {C_LMP_HI, clr_idx};
                ctype = CT_IO;
            end
            PH_WIPR: begin
                code  = {C_WIPR_HI, pg_idx};
                data  = {8'h00, pg_idx};
                ctype = CT_IO;
            end
            PH_WOPR: begin
                code  = {C_WOPR_HI, pg_idx};
                data  = {8'h00, pg_idx};
                ctype = CT_IO;
            end
            PH_ESUR: code = C_ESUR;
            PH_OTA:  code = C_OTA;
            PH_GO:   code = C_GO;
            PH_OTB:  code = C_OTB;
            PH_LD1, PH_LD2: begin
                kind  = K_MEM_RD;
                ctype = CT_M;
                data  = ic;
            end
            default: begin
                kind  = K_OP;
                ctype = CT_P;
            end
        endcase
    end
endmodule

// File: rtl/isq_init_seq.sv
module isq_init_seq
    import isq_pkg::*;
#(
    parameter int CLR_DEPTH = 128,
    parameter int PG_DEPTH  = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        odr_present,
    input  logic        bpu_present,
    input  logic        mmu_present,
    input  logic        step_ack,
    output logic        cmd_valid,
    output logic [15:0] cmd_code,
    output logic [15:0] cmd_data,
    output logic [1:0]  cmd_kind,
    output logic [2:0]  cyc_type,
    output logic        mmu_flag,
    output logic        done
);
    localparam int CLR_W = $clog2(CLR_DEPTH);
    localparam int PG_W  = $clog2(PG_DEPTH);
    localparam logic [CLR_W-1:0] CLR_LAST = CLR_W'(CLR_DEPTH - 1);
    localparam logic [PG_W-1:0]  PG_LAST  = PG_W'(PG_DEPTH - 1);

    typedef struct packed {
        phase_e           ph;
        logic [CLR_W-1:0] clr_cnt;
        logic [PG_W-1:0]  pg_cnt;
        logic [15:0]      ic;
        logic             mmu_seen;
        logic             mmu_flag;
    } state_t;

    // The instruction counter powers up all ones so its clear step matters.
    localparam state_t ST_RST = '{ph: PH_STS, clr_cnt: '0, pg_cnt: '0,
                                  ic: 16'hFFFF, mmu_seen: 1'b0, mmu_flag: 1'b0};

    state_t st_q, st_d;
    phase_e after_cfg, after_odr, after_bpu;
    kind_e  kind;
    ctype_e ctype;

    isq_route u_route (
        .odr_present (odr_present),
        .bpu_present (bpu_present),
        .mmu_present (mmu_present),
        .after_cfg   (after_cfg),
        .after_odr   (after_odr),
        .after_bpu   (after_bpu)
    );

    isq_step_rom u_rom (
        .phase   (st_q.ph),
        .clr_idx (8'(st_q.clr_cnt)),
        .pg_idx  (8'(st_q.pg_cnt)),
        .ic      (st_q.ic),
        .code    (cmd_code),
        .data    (cmd_data),
        .kind    (kind),
        .ctype   (ctype)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.ph != PH_DONE && step_ack) begin
            case (st_q.ph)
                PH_ICCLR: begin
                    st_d.ic = 16'h0000;
                    st_d.ph = PH_INTDIS;
                end
                PH_CFGRD: st_d.ph = after_cfg;
                PH_ODR:   st_d.ph = after_odr;
                PH_LMP: begin
                    if (st_q.clr_cnt == CLR_LAST) begin
                        st_d.clr_cnt = '0;
                        st_d.ph      = after_bpu;
                    end else begin
                        st_d.clr_cnt = st_q.clr_cnt + 1'b1;
                    end
                end
                PH_WIPR: st_d.ph = PH_WOPR;
                PH_WOPR: begin
                    if (st_q.pg_cnt == PG_LAST) begin
                        st_d.pg_cnt   = '0;
                        st_d.mmu_seen = 1'b1;
                        st_d.ph       = PH_FLAG;
                    end else begin
                        st_d.pg_cnt = st_q.pg_cnt + 1'b1;
                        st_d.ph     = PH_WIPR;
                    end
                end
                PH_FLAG: begin
                    st_d.mmu_flag = st_q.mmu_seen;
                    st_d.ph       = PH_ESUR;
                end
                PH_LD1: begin
                    st_d.ic = st_q.ic + 16'd1;
                    st_d.ph = PH_LD2;
                end
                PH_LD2: begin
                    st_d.ic = st_q.ic + 16'd1;
                    st_d.ph = PH_DONE;
                end
                default: st_d.ph = phase_e'(st_q.ph + 5'd1);
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    assign cmd_valid = (st_q.ph != PH_DONE);
    assign done      = (st_q.ph == PH_DONE);
    assign mmu_flag  = st_q.mmu_flag;
    assign cmd_kind  = kind;
    assign cyc_type  = ctype;

endmodule

// File: rtl/isq_init_seq_chk.sv
module isq_init_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        step_ack,
    input logic        cmd_valid,
    input logic [15:0] cmd_code,
    input logic [15:0] cmd_data,
    input logic [1:0]  cmd_kind,
    input logic [2:0]  cyc_type,
    input logic        mmu_flag,
    input logic        done
);
    // R2
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !step_ack) |=> ($stable(cmd_code) && $stable(cmd_data)
                                      && $stable(cmd_kind) && $stable(cyc_type)));

    // R12
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    // R12
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cmd_valid);

    // R8
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mmu_flag) |-> $past(step_ack && cmd_valid && cmd_kind == 2'd0));

    // R6
    lmp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && step_ack && cmd_code[15:8] == 8'h50 && cmd_code[7:0] != 8'd127)
        |=> (cmd_code == $past(cmd_code) + 16'd1));

    // R7
    page_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && step_ack && cmd_code[15:8] == 8'h51)
        |=> (cmd_code == {8'h52, $past(cmd_code[7:0])} && cmd_data == $past(cmd_data)));

    // R11
    load_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 2'd3) |-> (cyc_type == 3'd2));
endmodule

bind isq_init_seq isq_init_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_ack  (step_ack),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_data  (cmd_data),
    .cmd_kind  (cmd_kind),
    .cyc_type  (cyc_type),
    .mmu_flag  (mmu_flag),
    .done      (done)
);

// File: tb/tb_isq_init_seq.sv
module tb_isq_init_seq;
    localparam int T_P = 0, T_IO = 1, T_M = 2, T_B1 = 3, T_B2 = 4;
    localparam int K_OP = 0, K_IIO = 1, K_EIO = 2, K_MRD = 3;

    typedef struct {
        int    code;
        int    data;
        int    kind;
        int    ctype;
        string req;
        bit    is_flag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        odr_present = 1'b0, bpu_present = 1'b0, mmu_present = 1'b0;
    logic        step_ack = 1'b0;
    logic        cmd_valid, mmu_flag, done;
    logic [15:0] cmd_code, cmd_data;
    logic [1:0]  cmd_kind;
    logic [2:0]  cyc_type;

    int   n_vec = 0;
    int   n_bad = 0;
    exp_t exq[$];

    always #10 clk = ~clk;

    isq_init_seq dut (
        .clk(clk), .rst_n(rst_n),
        .odr_present(odr_present), .bpu_present(bpu_present), .mmu_present(mmu_present),
        .step_ack(step_ack), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_data(cmd_data), .cmd_kind(cmd_kind), .cyc_type(cyc_type),
        .mmu_flag(mmu_flag), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic push(input int code, input int data, input int kind,
                        input int ctype, input string req, input bit fl);
        exp_t e;
        e.code = code; e.data = data; e.kind = kind;
        e.ctype = ctype; e.req = req; e.is_flag = fl;
        exq.push_back(e);
    endtask

    task automatic build(input bit o, input bit b, input bit m);
        exq.delete();
        push(0, 0, K_OP, T_B1, "R1", 0);
        push('h2000, 0, K_IIO, T_P, "R3", 0);
        push('h2001, 0, K_IIO, T_P, "R3", 0);
        push(0, 0, K_OP, T_B1, "R3", 0);
        push('h2003, 0, K_IIO, T_P, "R3", 0);
        push('h200E, 0, K_IIO, T_P, "R4", 0);
        push('h4007, 0, K_IIO, T_P, "R3", 0);
        push('h8400, 0, K_IIO, T_B2, "R3", 0);
        if (o) push(0, 0, K_EIO, T_IO, "R5", 0);
        if (b) for (int a = 0; a < 128; a++) push('h5000 + a, 0, K_IIO, T_IO, "R6", 0);
        if (m) for (int i = 0; i < 256; i++) begin
            push('h5100 + i, i, K_IIO, T_IO, "R7", 0);
            push('h5200 + i, i, K_IIO, T_IO, "R7", 0);
        end
        push(0, 0, K_OP, T_B1, "R8", 1);
        push('h4004, 0, K_IIO, T_P, "R9", 0);
        push('h400A, 0, K_IIO, T_P, "R9", 0);
        push('h400B, 0, K_IIO, T_P, "R9", 0);
        push('h400E, 0, K_IIO, T_P, "R9", 0);
        push(0, 0, K_MRD, T_M, "R10", 0);
        push(0, 1, K_MRD, T_M, "R10", 0);
    endtask

    // Runs the model against the DUT; stops after 'abort_at' accepts if nonzero.
    task automatic run(input bit o, input bit b, input bit m, input int abort_at);
        bit          exp_flag = 0;
        bit          prev_ack = 0;
        bit          have_prev = 0;
        logic [15:0] p_code = '0, p_data = '0;
        logic [1:0]  p_kind = '0;
        logic [2:0]  p_type = '0;
        int          tail = 0;
        int          pops = 0;
        build(o, b, m);
        odr_present = o; bpu_present = b; mmu_present = m;
        step_ack = 0;
        @(negedge clk);
        rst_n = 0;
        #1;
        // R1 / R13: state while reset is held
        chk(cmd_valid === 1'b1, "R13", "valid in reset", int'(cmd_valid), 1);
        chk(done === 1'b0, "R1", "done in reset", int'(done), 0);
        chk(mmu_flag === 1'b0, "R13", "flag in reset", int'(mmu_flag), 0);
        chk(cmd_code === 16'h0, "R13", "code in reset", int'(cmd_code), 0);
        repeat (2) @(negedge clk);
        rst_n = 1;
        while (1) begin
            @(negedge clk);
            if (have_prev && !prev_ack && exq.size() != 0) begin
                chk(cmd_code == p_code && cmd_data == p_data && cmd_kind == p_kind
                    && cyc_type == p_type, "R2", "held step", int'(cmd_code), int'(p_code));
            end
            chk(mmu_flag === exp_flag, "R8", "mmu_flag", int'(mmu_flag), int'(exp_flag));
            if (exq.size() == 0) begin
                chk(done === 1'b1, "R12", "done", int'(done), 1);
                chk(cmd_valid === 1'b0, "R12", "valid after done", int'(cmd_valid), 0);
                tail++;
                step_ack = tail[0];
                if (tail > 5) break;
                continue;
            end
            chk(done === 1'b0, "R12", "done early", int'(done), 0);
            chk(cmd_valid === 1'b1, exq[0].req, "valid", int'(cmd_valid), 1);
            chk(int'(cmd_code) == exq[0].code, exq[0].req, "code", int'(cmd_code), exq[0].code);
            chk(int'(cmd_data) == exq[0].data, exq[0].req, "data", int'(cmd_data), exq[0].data);
            chk(int'(cmd_kind) == exq[0].kind, "R11", "kind", int'(cmd_kind), exq[0].kind);
            chk(int'(cyc_type) == exq[0].ctype, "R11", "type", int'(cyc_type), exq[0].ctype);
            p_code = cmd_code; p_data = cmd_data; p_kind = cmd_kind; p_type = cyc_type;
            have_prev = 1;
            step_ack = ($urandom_range(0, 2) != 0);
            prev_ack = step_ack;
            if (step_ack) begin
                if (exq[0].is_flag) exp_flag = m;
                void'(exq.pop_front());
                pops++;
                if (abort_at != 0 && pops == abort_at) begin
                    @(negedge clk);
                    step_ack = 0;
                    break;
                end
            end
        end
        step_ack = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R13: abort in the middle of the protection clear loop, then restart
        run(1'b1, 1'b1, 1'b1, 40);
        for (int s = 0; s < 8; s++) run(s[0], s[1], s[2], 0);
        run(1'b0, 1'b1, 1'b0, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule